// File: doc/BRIEF.md
# Configurable AND-OR Logic Plane

This block is a small programmable two-layer logic array. The first layer builds product terms: each term is the AND of any chosen set of literals, and each input variable can appear in its true or complemented form. The second layer builds the outputs: each output is the OR of a set of product terms. The variables are the primary input bus together with a feedback input bus. The surrounding logic can route registered outputs back through the feedback bus.

A single mode bit selects how the OR layer is wired. In fixed-OR mode each output sums a hard-wired, contiguous group of product terms, and only the AND connections are programmable. In programmable-OR mode every output has its own connection bit for every product term. All connection bits, and the mode bit, are shifted in serially on a configuration clock while a load enable is high. They hold their values after the enable drops. The outputs stay at 0 for as long as a load is in progress.

Top module: `sop_plane`

## Requirements
- R1: Each output equals the OR, over the product terms connected to it, of the AND of each term's connected literals, for arbitrary configurations and input values.
- R2: Literal encoding: for term t and variable v, the bit at chain index OR_W + t*2*NV + 2*v + 1 connects the true form, and the bit at OR_W + t*2*NV + 2*v connects the complemented form. Here NV = N_IN + N_FB and OR_W = N_OUT*N_TERM.
- R3: A variable whose two connection bits are both clear has no effect on the term, as if it were tied to logic 1.
- R4: A product term with no connection bit set is unused and contributes logic 0 to every output.
- R5: If both the true and the complemented bit of one variable are set in a term, that term is always 0.
- R6: In fixed-OR mode (mode bit = 0), output o sums exactly terms o*TPO to o*TPO+TPO-1, where TPO = N_TERM/N_OUT. The OR connection bits in the chain are ignored.
- R7: In programmable-OR mode (mode bit = 1), output o sums each term t whose bit at chain index o*N_TERM + t is set.
- R8: While the load enable is high, one bit shifts in per configuration clock, most significant first. The chain is 1 + 2*N_TERM*NV + OR_W bits long, and the mode bit ends at the top index. With the enable low, the configuration does not change whatever the data pin does.
- R9: All outputs are 0 while the load enable is high.
- R10: Reset clears the whole configuration, so every output is 0 after reset.
- R11: Variable v is in_i[v] for v < N_IN and fb_i[v-N_IN] otherwise. The feedback bits act exactly like primary inputs.
- R12: Loaded with y = a·b + a'·b'·c·d (a to d on in_i[0] to in_i[3]), output 0 follows that function over all 16 input combinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en_i | input | 1 | Load enable; shifts the chain and forces the outputs low |
| cfg_din_i | input | 1 | Serial configuration data, most significant bit first |
| in_i | input | N_IN | Primary input variables |
| fb_i | input | N_FB | Feedback input variables |
| y_o | output | N_OUT | Sum-of-products outputs |

## Verification
The clocked assertions sample combinational outputs at configuration-clock edges. They therefore assume that in_i and fb_i are stable around those edges, and that the configuration is only meaningful once a full chain length has been shifted. The bench changes the inputs only on falling edges. Every load it performs shifts exactly the chain length, and after each load it drops the enable before judging any output. Random configurations weight literal choices so that product terms are often live, and a few terms are left deliberately empty or conflicting.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic {
    MODE_FIXED_OR = 1'b0,
    MODE_PROG_OR  = 1'b1
  } or_mode_e;
endpackage

// File: rtl/sop_rst_sync.sv
module sop_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] cfg_o
);
  logic [W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (en_i) cfg_d = {cfg_q[W-2:0], din_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cfg_q)); // R8
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int unsigned N_VAR  = 6,
  parameter int unsigned N_TERM = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_VAR-1:0]          lit_i,
  input  logic [N_TERM*2*N_VAR-1:0] conn_i,
  output logic [N_TERM-1:0]         term_o
);
  localparam int unsigned ROW_W = 2 * N_VAR;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [ROW_W-1:0] row;
    logic [N_VAR-1:0] pos_sel, neg_sel;
    logic             prod;

    assign row = conn_i[t*ROW_W +: ROW_W];

    for (genvar v = 0; v < N_VAR; v++) begin : g_split
      assign pos_sel[v] = row[2*v+1];
      assign neg_sel[v] = row[2*v];
    end

    always_comb begin
      prod = 1'b1;
      for (int v = 0; v < N_VAR; v++) begin
        if (pos_sel[v] && !lit_i[v]) prod = 1'b0;
        if (neg_sel[v] &&  lit_i[v]) prod = 1'b0;
      end
    end

    assign term_o[t] = (|row) & prod;

    AST_EMPTY_TERM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (row == '0) |-> !term_o[t]); // R4
    AST_CONFLICT_TERM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(pos_sel & neg_sel)) |-> !term_o[t]); // R5
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int unsigned N_TERM = 8,
  parameter int unsigned N_OUT  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  sop_pkg::or_mode_e        mode_i,
  input  logic                     hold_i,
  input  logic [N_TERM-1:0]        term_i,
  input  logic [N_OUT*N_TERM-1:0]  or_cfg_i,
  output logic [N_OUT-1:0]         y_o
);
  import sop_pkg::*;

  localparam int unsigned TPO = N_TERM / N_OUT;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_TERM-1:0] grp, row, sel;

    for (genvar t = 0; t < N_TERM; t++) begin : g_grp
      assign grp[t] = ((t / TPO) == o) ? 1'b1 : 1'b0;
    end

    assign row     = or_cfg_i[o*N_TERM +: N_TERM];
    assign sel     = (mode_i == MODE_PROG_OR) ? row : grp;
    assign y_o[o]  = !hold_i && (|(term_i & sel));

    AST_FIXED_GROUP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mode_i == MODE_FIXED_OR) && ((term_i & grp) == '0)) |-> !y_o[o]); // R6
    AST_PROG_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mode_i == MODE_PROG_OR) && !hold_i && (|(term_i & row))) |-> y_o[o]); // R7
  end
endmodule

// File: rtl/sop_plane.sv
module sop_plane #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_FB   = 2,
  parameter int unsigned N_TERM = 8,
  parameter int unsigned N_OUT  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_din_i,
  input  logic [N_IN-1:0]   in_i,
  input  logic [N_FB-1:0]   fb_i,
  output logic [N_OUT-1:0]  y_o
);
  import sop_pkg::*;

  localparam int unsigned N_VAR = N_IN + N_FB;
  localparam int unsigned AND_W = N_TERM * 2 * N_VAR;
  localparam int unsigned OR_W  = N_OUT * N_TERM;
  localparam int unsigned CFG_W = 1 + AND_W + OR_W;

  logic              rst_sync_n;
  logic [CFG_W-1:0]  cfg;
  logic [N_VAR-1:0]  lit;
  logic [N_TERM-1:0] terms;
  or_mode_e          mode;

  sop_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  sop_cfg_chain #(.W(CFG_W)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .en_i   (cfg_en_i),
    .din_i  (cfg_din_i),
    .cfg_o  (cfg)
  );

  assign lit  = {fb_i, in_i};
  assign mode = or_mode_e'(cfg[CFG_W-1]);

  sop_and_plane #(.N_VAR(N_VAR), .N_TERM(N_TERM)) u_and (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .lit_i  (lit),
    .conn_i (cfg[OR_W +: AND_W]),
    .term_o (terms)
  );

  sop_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .mode_i   (mode),
    .hold_i   (cfg_en_i),
    .term_i   (terms),
    .or_cfg_i (cfg[OR_W-1:0]),
    .y_o      (y_o)
  );

  AST_QUIET_DURING_LOAD: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    cfg_en_i |-> (y_o == '0)); // R9
endmodule

// File: tb/sop_plane_tb.sv
module sop_plane_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN   = 4;
  localparam int N_FB   = 2;
  localparam int N_TERM = 8;
  localparam int N_OUT  = 2;
  localparam int NV     = N_IN + N_FB;
  localparam int OR_W   = N_OUT * N_TERM;
  localparam int CFG_W  = 1 + N_TERM*2*NV + OR_W;
  localparam int TPO    = N_TERM / N_OUT;

  logic clk, rst_n, cfg_en, cfg_din;
  logic [N_IN-1:0]  in_v;
  logic [N_FB-1:0]  fb_v;
  logic [N_OUT-1:0] y;
  logic [CFG_W-1:0] cfg_v;
  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  sop_plane #(.N_IN(N_IN), .N_FB(N_FB), .N_TERM(N_TERM), .N_OUT(N_OUT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_din_i(cfg_din),
    .in_i(in_v), .fb_i(fb_v), .y_o(y));

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic logic [N_OUT-1:0] model(input logic [CFG_W-1:0] c, input logic [NV-1:0] x);
    logic [N_TERM-1:0] term;
    logic [N_OUT-1:0]  r;
    for (int t = 0; t < N_TERM; t++) begin
      logic used, prod;
      used = 0; prod = 1;
      for (int v = 0; v < NV; v++) begin
        logic tb, cb;
        tb = c[OR_W + t*2*NV + 2*v + 1];
        cb = c[OR_W + t*2*NV + 2*v];
        used = used | tb | cb;
        if (tb && !x[v]) prod = 0;
        if (cb &&  x[v]) prod = 0;
      end
      term[t] = used & prod;
    end
    for (int o = 0; o < N_OUT; o++) begin
      r[o] = 0;
      for (int t = 0; t < N_TERM; t++) begin
        if (c[CFG_W-1]) begin
          if (c[o*N_TERM + t] && term[t]) r[o] = 1;
        end else begin
          if ((t / TPO) == o && term[t]) r[o] = 1;
        end
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [N_OUT-1:0] act, input logic [N_OUT-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic put_lit(input int t, input int v, input bit comp);
    cfg_v[OR_W + t*2*NV + 2*v + (comp ? 0 : 1)] = 1'b1;
  endtask

  task automatic put_or(input int o, input int t);
    cfg_v[o*N_TERM + t] = 1'b1;
  endtask

  task automatic apply(input logic [NV-1:0] x);
    @(negedge clk);
    in_v = x[N_IN-1:0];
    fb_v = x[NV-1:N_IN];
    #1;
  endtask

  task automatic load(input bit probe);
    for (int i = CFG_W-1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en  = 1;
      cfg_din = cfg_v[i];
      if (probe && i == CFG_W/2) begin
        in_v = 4'b0011;
        #1;
        check("R9 outputs low while loading", y, '0);
      end
    end
    @(negedge clk);
    cfg_en = 0;
    cfg_din = 0;
  endtask

  task automatic sweep(input string req, input logic [CFG_W-1:0] ref_cfg);
    for (int x = 0; x < (1 << NV); x++) begin
      logic [NV-1:0] xv;
      xv = x[NV-1:0];
      apply(xv);
      check(req, y, model(ref_cfg, xv));
    end
  endtask

  task automatic random_cfg();
    cfg_v = '0;
    cfg_v[CFG_W-1] = 1'($urandom % 2);
    for (int t = 0; t < N_TERM; t++) begin
      if ($urandom % 7 != 0) begin
        for (int v = 0; v < NV; v++) begin
          int r;
          r = int'($urandom % 100);
          if (r >= 45 && r < 70) put_lit(t, v, 0);
          else if (r >= 70 && r < 94) put_lit(t, v, 1);
          else if (r >= 94) begin put_lit(t, v, 0); put_lit(t, v, 1); end
        end
      end
    end
    for (int i = 0; i < OR_W; i++) cfg_v[i] = ($urandom % 3 == 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [CFG_W-1:0] tmp;
    void'($urandom(32'd1234));
    rst_n = 0; cfg_en = 0; cfg_din = 0; in_v = '0; fb_v = '0; cfg_v = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R10: cleared configuration gives all-zero outputs
    sweep("R10 reset state", '0);

    // R12 R3 R4: fixed-OR mode, term0 = a b, term1 = a' b' c d, terms 2 and 3 empty
    cfg_v = '0;
    put_lit(0, 0, 0); put_lit(0, 1, 0);
    put_lit(1, 0, 1); put_lit(1, 1, 1); put_lit(1, 2, 0); put_lit(1, 3, 0);
    load(0);
    for (int x = 0; x < 16; x++) begin
      logic a, b, c, d, e;
      a = x[0]; b = x[1]; c = x[2]; d = x[3];
      e = (a & b) | (~a & ~b & c & d);
      apply({2'($urandom), 4'(x)});
      check("R12 example function", y[0], e);
      check("R4 empty terms on output1", y[1], 1'b0);
    end

    // R9: reload the same pattern, probing midway; then R12 again
    load(1);
    apply({2'b00, 4'b0011});
    check("R12 after reload", y, 2'b01);

    // R8: with enable low the data pin cannot disturb the configuration
    tmp = cfg_v;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      cfg_din = 1'($urandom);
    end
    cfg_din = 0;
    sweep("R8 config held", tmp);

    // R2 R3: term0 = c (out0), term TPO = b' (out1)
    cfg_v = '0;
    put_lit(0, 2, 0);
    put_lit(TPO, 1, 1);
    load(0);
    for (int x = 0; x < (1 << NV); x++) begin
      logic [NV-1:0] xv;
      xv = x[NV-1:0];
      apply(xv);
      check("R2 R3 literal selection", y, {~xv[1], xv[2]});
    end

    // R5: conflicting literal in the only term of output0
    cfg_v = '0;
    put_lit(0, 0, 0); put_lit(0, 0, 1); put_lit(0, 3, 0);
    load(0);
    sweep("R5 conflict term", '0);

    // R7 R11: programmable OR routes term0 (fb0 & ~a) to output1 only
    cfg_v = '0;
    cfg_v[CFG_W-1] = 1'b1;
    put_lit(0, N_IN, 0); put_lit(0, 0, 1);
    put_or(1, 0);
    load(0);
    for (int x = 0; x < (1 << NV); x++) begin
      logic [NV-1:0] xv;
      xv = x[NV-1:0];
      apply(xv);
      check("R7 R11 routed feedback term", y, {xv[N_IN] & ~xv[0], 1'b0});
    end

    // R6: fixed-OR mode with random OR bits equals same with OR bits cleared
    for (int k = 0; k < 4; k++) begin
      random_cfg();
      cfg_v[CFG_W-1] = 1'b0;
      tmp = cfg_v;
      tmp[OR_W-1:0] = '0;
      load(0);
      sweep("R6 OR bits ignored", tmp);
    end

    // R1: random configurations in both modes
    for (int k = 0; k < 16; k++) begin
      random_cfg();
      load(0);
      sweep("R1 random SOP", cfg_v);
    end

    // R10: reset after configuration clears it
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    sweep("R10 reset clears config", '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule